// File: doc/BRIEF.md
# Coverage-Weighted Bisection Fault Diagnosis Controller

This block runs an adaptive built-in self-test diagnosis. It holds a small table of diagnostic points. A diagnostic point is a test pattern that detects at least one fault that no earlier pattern detects. For each point the table stores four things: the pattern number, the pseudorandom generator state of the following pattern, the signature that the compactor holds once that pattern has been applied, and a 2-bit-per-fault detection vector. Each session reseeds an on-chip LFSR pattern source and a MISR compactor. The session then applies a window of patterns to the circuit under test, which sits outside the block. At the end of the window the controller compares the compacted response with the stored signature.

The controller picks window ends so that each window covers a fraction of the fault coverage that is still open, rather than a fraction of the pattern count. It does so by halving a coverage step. When a window of a single diagnostic point fails, that point is isolated. The suspected-fault vector is then ANDed with the detection vector of that point. All later entries are seen through the new suspected mask, the cumulative counts are rebuilt, and the search starts again at half coverage. Diagnosis ends early when the suspected set becomes small enough, when enough failing points have been found, or when the pattern sequence runs out.

Top module: `cov_bisect_diag`

## Requirements
- R1: While reset is high and in the cycle after it is released, done_o is 0, sessions_o is 0 and susp_o is all zeros.
- R2: A start pulse while idle does four things: it sets the suspected vector to all ones, clears the session count, builds the cumulative covered-fault counts from entry 0, and sets both the coverage step and the target to floor(total/2). The count for an entry is the number of set bits in the OR of the masked vectors from the restart entry up to that entry. The window end is the first entry at or after the window start whose count reaches the target, or the last entry if none does.
- R3: A session with window start s and end e does the following. It loads the LFSR with the next-pattern state of entry s-1 and the MISR with the signature of entry s-1, or with the parameter seeds when s is 0. It applies pat(e)-pat(s-1) patterns, with pat(-1)=0, absorbing cut_i into the MISR once per pattern. It then compares the MISR with the signature of entry e, and sessions_o increases by exactly 1 at that comparison.
- R4: Before each decision the step becomes max(step/2, 1). On a matching signature the next start is e+1 and the next target is count(e)+step.
- R5: On a mismatch over a window of more than one entry, the start is kept, the next target is count(s-1)+step (0 when s is the restart entry), and the next end is forced strictly below the old end.
- R6: A mismatch over a window of exactly one entry isolates that entry. The suspected vector is ANDed with the detection vector of that entry. Bit 2i marks stuck-at-0 on fault i and bit 2i+1 marks stuck-at-1. A set bit in the suspected vector is never set again during a run.
- R7: After an isolation, the search restarts at the entry after the isolated one. Later detection vectors are masked by the suspected vector, and the counts and targets are rebuilt as in R2 from that entry.
- R8: When a window ending at the last entry matches, every fault bit detected by the masked entries from the restart entry to the last entry is cleared from the suspected vector, and the run ends.
- R9: The run ends after an isolation when the number of set suspected bits is at most cfg_res_i.
- R10: The run ends after an isolation when the number of isolated entries reaches cfg_maxfail_i.
- R11: Isolating the last entry ends the run, and no further session follows.
- R12: The end of a run is marked by done_o high for exactly one cycle. susp_o and sessions_o then stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken while idle |
| cfg_res_i | input | CW | Acceptable number of suspected fault bits |
| cfg_maxfail_i | input | FAIL_W | Number of isolated entries that ends the run |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | IDX_W | Table entry index |
| wr_pat_i | input | PAT_W | Pattern number of the entry |
| wr_lfsr_i | input | SIG_W | Generator state of the pattern after the entry |
| wr_sig_i | input | SIG_W | Fault-free signature after the entry |
| wr_fault_i | input | 2*NUM_FAULTS | Detection vector, 2 bits per fault |
| pat_o | output | SIG_W | Current test pattern to the circuit under test |
| cut_i | input | SIG_W | Circuit response for pat_o, compacted in the same cycle |
| done_o | output | 1 | One-cycle end-of-run pulse |
| susp_o | output | 2*NUM_FAULTS | Suspected-fault vector |
| sessions_o | output | SES_W | Number of signature comparisons in this run |

## Verification
The assertions take four things for granted about the inputs. The table is written only while the block is idle. Pattern numbers increase strictly from entry to entry and start at 1 or more. cfg_maxfail_i is at least 1. start_i is pulsed only when no run is in progress. The stimulus loads all entries before the first start. It then starts each run only after the done pulse of the previous one. Its circuit model corrupts a response only at the pattern of an entry that detects the injected fault, so every failing window holds a known set of erroneous patterns that the primitive compactor polynomial cannot cancel.

// File: rtl/diag_pkg.sv
package diag_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RB_RD, S_RB_ACC, S_PICK, S_PRV_RD, S_PRV_CAP,
    S_END_RD, S_END_CAP, S_RUN, S_CMP, S_DONE
  } diag_st_t;
endpackage

// File: rtl/dp_table_ram.sv
module dp_table_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pat_lfsr.sv
module pat_lfsr #(
  parameter int         W    = 8,
  parameter logic [W-1:0] POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst)       state_q <= W'(1);
    else if (load) state_q <= load_val;
    else if (en)   state_q <= {state_q[W-2:0], 1'b0} ^ (state_q[W-1] ? POLY : '0);
  end

  assign state_o = state_q;

  assert_gen_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(state_q));
endmodule

// File: rtl/sig_misr.sv
module sig_misr #(
  parameter int         W    = 8,
  parameter logic [W-1:0] POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (rst)       sig_q <= '0;
    else if (load) sig_q <= load_val;
    else if (en)   sig_q <= ({sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0)) ^ din;
  end

  assign sig_o = sig_q;

  assert_misr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(sig_q));
endmodule

// File: rtl/cov_end_pick.sv
module cov_end_pick #(
  parameter int NUM_DP = 8,
  parameter int IDX_W  = 3,
  parameter int CW     = 4,
  parameter int TW     = 5
) (
  input  logic [NUM_DP*CW-1:0] cum_i,
  input  logic [IDX_W:0]       s_i,
  input  logic [TW-1:0]        tgt_i,
  input  logic [IDX_W-1:0]     lim_i,
  output logic [IDX_W-1:0]     e_o
);
  logic [IDX_W-1:0] cand;

  always_comb begin
    cand = IDX_W'(NUM_DP - 1);
    for (int i = NUM_DP - 1; i >= 0; i--) begin
      if ((IDX_W+1)'(i) >= s_i && TW'(cum_i[i*CW +: CW]) >= tgt_i)
        cand = IDX_W'(i);
    end
    e_o = (cand > lim_i) ? lim_i : cand;
  end
endmodule

// File: rtl/cov_bisect_diag.sv
module cov_bisect_diag #(
  parameter int             NUM_DP     = 8,
  parameter int             NUM_FAULTS = 5,
  parameter int             PAT_W      = 8,
  parameter int             SIG_W      = 8,
  parameter int             SES_W      = 8,
  parameter int             FAIL_W     = 4,
  parameter logic [SIG_W-1:0] POLY      = 8'h1D,
  parameter logic [SIG_W-1:0] LFSR_SEED = 8'h01,
  parameter logic [SIG_W-1:0] MISR_SEED = 8'h00,
  localparam int FB    = 2 * NUM_FAULTS,
  localparam int IDX_W = $clog2(NUM_DP),
  localparam int CW    = $clog2(FB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CW-1:0]     cfg_res_i,
  input  logic [FAIL_W-1:0] cfg_maxfail_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [PAT_W-1:0]  wr_pat_i,
  input  logic [SIG_W-1:0]  wr_lfsr_i,
  input  logic [SIG_W-1:0]  wr_sig_i,
  input  logic [FB-1:0]     wr_fault_i,
  output logic [SIG_W-1:0]  pat_o,
  input  logic [SIG_W-1:0]  cut_i,
  output logic              done_o,
  output logic [FB-1:0]     susp_o,
  output logic [SES_W-1:0]  sessions_o
);
  import diag_pkg::*;

  localparam int TW = CW + 1;
  localparam int EW = PAT_W + 2 * SIG_W + FB;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DP - 1);

  diag_st_t st_q;
  logic [IDX_W:0]        s_q, base_q;
  logic [IDX_W-1:0]      e_q, lim_q, k_q;
  logic [TW-1:0]         step_q, tgt_q;
  logic [FB-1:0]         susp_q, uni_q, end_flt_q;
  logic [NUM_DP*CW-1:0]  cum_q;
  logic [FAIL_W-1:0]     fails_q, mf_q;
  logic [CW-1:0]         thr_q;
  logic [SES_W-1:0]      ses_q;
  logic [PAT_W-1:0]      prv_pat_q, cnt_q;
  logic [SIG_W-1:0]      end_sig_q;
  logic                  done_q;

  // table read port
  logic                  rd_en;
  logic [IDX_W-1:0]      rd_addr;
  logic [EW-1:0]         rdata;
  logic [PAT_W-1:0]      rd_pat;
  logic [SIG_W-1:0]      rd_lfsr, rd_sig;
  logic [FB-1:0]         rd_flt;

  dp_table_ram #(.DEPTH(NUM_DP), .W(EW)) u_tab (
    .clk(clk), .we(wr_en_i), .waddr(wr_addr_i),
    .wdata({wr_pat_i, wr_lfsr_i, wr_sig_i, wr_fault_i}),
    .re(rd_en), .raddr(rd_addr), .rdata(rdata)
  );

  assign rd_pat  = rdata[EW-1 -: PAT_W];
  assign rd_lfsr = rdata[FB+SIG_W +: SIG_W];
  assign rd_sig  = rdata[FB +: SIG_W];
  assign rd_flt  = rdata[FB-1:0];

  logic [IDX_W-1:0] s_idx, sm1;
  assign s_idx = s_q[IDX_W-1:0];
  assign sm1   = s_idx - 1'b1;

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = k_q;
    case (st_q)
      S_RB_RD:  begin rd_en = 1'b1; rd_addr = k_q; end
      S_PRV_RD: begin rd_en = 1'b1; rd_addr = sm1; end
      S_END_RD: begin rd_en = 1'b1; rd_addr = e_q; end
      default:  ;
    endcase
  end

  // generator and compactor
  logic             gen_load, gen_en;
  logic [SIG_W-1:0] lfsr_ld, misr_ld, misr_q;

  assign gen_load = (st_q == S_PICK && s_q == '0) || (st_q == S_PRV_CAP);
  assign gen_en   = (st_q == S_RUN);
  assign lfsr_ld  = (st_q == S_PRV_CAP) ? rd_lfsr : LFSR_SEED;
  assign misr_ld  = (st_q == S_PRV_CAP) ? rd_sig  : MISR_SEED;

  pat_lfsr #(.W(SIG_W), .POLY(POLY)) u_gen (
    .clk(clk), .rst(rst), .load(gen_load), .load_val(lfsr_ld),
    .en(gen_en), .state_o(pat_o)
  );

  sig_misr #(.W(SIG_W), .POLY(POLY)) u_misr (
    .clk(clk), .rst(rst), .load(gen_load), .load_val(misr_ld),
    .en(gen_en), .din(cut_i), .sig_o(misr_q)
  );

  // window end selection
  logic [IDX_W-1:0] pick_e;

  cov_end_pick #(.NUM_DP(NUM_DP), .IDX_W(IDX_W), .CW(CW), .TW(TW)) u_pick (
    .cum_i(cum_q), .s_i(s_q), .tgt_i(tgt_q), .lim_i(lim_q), .e_o(pick_e)
  );

  function automatic logic [CW-1:0] ones(input logic [FB-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < FB; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  logic [FB-1:0]  acc_u, nsusp;
  logic [CW-1:0]  acc_n, cb, cum_e;
  logic [TW-1:0]  nstep;
  logic           fail_w;

  assign acc_u  = uni_q | (rd_flt & susp_q);
  assign acc_n  = ones(acc_u);
  assign nsusp  = susp_q & end_flt_q;
  assign cb     = (s_q == base_q) ? '0 : cum_q[sm1*CW +: CW];
  assign cum_e  = cum_q[e_q*CW +: CW];
  assign nstep  = ((step_q >> 1) == '0) ? TW'(1) : (step_q >> 1);
  assign fail_w = (misr_q != end_sig_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE;
      s_q <= '0; base_q <= '0; e_q <= '0; lim_q <= '0; k_q <= '0;
      step_q <= '0; tgt_q <= '0; susp_q <= '0; uni_q <= '0; end_flt_q <= '0;
      cum_q <= '0; fails_q <= '0; mf_q <= '0; thr_q <= '0; ses_q <= '0;
      prv_pat_q <= '0; cnt_q <= '0; end_sig_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          susp_q  <= '1;
          ses_q   <= '0;
          fails_q <= '0;
          base_q  <= '0;
          k_q     <= '0;
          uni_q   <= '0;
          thr_q   <= cfg_res_i;
          mf_q    <= cfg_maxfail_i;
          st_q    <= S_RB_RD;
        end
        S_RB_RD: st_q <= S_RB_ACC;
        S_RB_ACC: begin
          uni_q <= acc_u;
          cum_q[k_q*CW +: CW] <= acc_n;
          if (k_q == LAST) begin
            step_q <= TW'(acc_n >> 1);
            tgt_q  <= TW'(acc_n >> 1);
            s_q    <= base_q;
            lim_q  <= LAST;
            st_q   <= S_PICK;
          end else begin
            k_q  <= k_q + 1'b1;
            st_q <= S_RB_RD;
          end
        end
        S_PICK: begin
          e_q <= pick_e;
          if (s_q == '0) begin
            prv_pat_q <= '0;
            st_q      <= S_END_RD;
          end else begin
            st_q <= S_PRV_RD;
          end
        end
        S_PRV_RD:  st_q <= S_PRV_CAP;
        S_PRV_CAP: begin
          prv_pat_q <= rd_pat;
          st_q      <= S_END_RD;
        end
        S_END_RD:  st_q <= S_END_CAP;
        S_END_CAP: begin
          end_sig_q <= rd_sig;
          end_flt_q <= rd_flt & susp_q;
          cnt_q     <= rd_pat - prv_pat_q;
          st_q      <= S_RUN;
        end
        S_RUN: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q <= PAT_W'(1)) st_q <= S_CMP;
        end
        S_CMP: begin
          ses_q  <= ses_q + 1'b1;
          step_q <= nstep;
          if (!fail_w) begin
            if (e_q == LAST) begin
              susp_q <= susp_q & ~uni_q;
              st_q   <= S_DONE;
            end else begin
              s_q   <= {1'b0, e_q} + 1'b1;
              tgt_q <= TW'(cum_e) + nstep;
              lim_q <= LAST;
              st_q  <= S_PICK;
            end
          end else if (s_idx != e_q) begin
            tgt_q <= TW'(cb) + nstep;
            lim_q <= e_q - 1'b1;
            st_q  <= S_PICK;
          end else begin
            susp_q  <= nsusp;
            fails_q <= fails_q + 1'b1;
            base_q  <= {1'b0, e_q} + 1'b1;
            k_q     <= e_q + 1'b1;
            uni_q   <= '0;
            if (ones(nsusp) <= thr_q || (fails_q + 1'b1) >= mf_q || e_q == LAST)
              st_q <= S_DONE;
            else
              st_q <= S_RB_RD;
          end
        end
        S_DONE: begin
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done_o     = done_q;
  assign susp_o     = susp_q;
  assign sessions_o = ses_q;

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && !start_i) |=> ($stable(susp_q) && $stable(ses_q)));

  assert_susp_shrink_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q != S_IDLE) |=> ((susp_q & ~$past(susp_q)) == '0));

  assert_session_step_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_CMP) |=> (ses_q == $past(ses_q) + 1'b1));

  assert_end_range_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_PICK) |-> ({1'b0, pick_e} >= s_q && pick_e <= lim_q));

  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_CMP && fail_w && s_idx == e_q) |=> (uni_q == '0));
endmodule

// File: tb/cov_bisect_diag_tb_top.sv
module cov_bisect_diag_tb_top;
  localparam int NDP = 8;
  localparam int NF  = 5;
  localparam int FB  = 2 * NF;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [3:0] cfg_res;
  logic [3:0] cfg_mf;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_pat, wr_lfsr, wr_sig;
  logic [FB-1:0] wr_flt;
  logic [7:0] pat, cut;
  logic       done;
  logic [FB-1:0] susp;
  logic [7:0] ses;

  always #5 clk = ~clk;

  cov_bisect_diag #(.NUM_DP(NDP), .NUM_FAULTS(NF)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .cfg_res_i(cfg_res),
    .cfg_maxfail_i(cfg_mf), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_pat_i(wr_pat), .wr_lfsr_i(wr_lfsr), .wr_sig_i(wr_sig),
    .wr_fault_i(wr_flt), .pat_o(pat), .cut_i(cut), .done_o(done),
    .susp_o(susp), .sessions_o(ses)
  );

  // diagnostic-point table (offline data)
  localparam logic [7:0]    ENT_PAT [NDP] = '{8'd1, 8'd2, 8'd3, 8'd5, 8'd6, 8'd8, 8'd10, 8'd12};
  localparam logic [FB-1:0] ENT_FLT [NDP] = '{10'h003, 10'h006, 10'h008, 10'h011,
                                              10'h022, 10'h040, 10'h084, 10'h301};

  typedef struct packed {
    logic [3:0]    flt;
    logic [3:0]    thr;
    logic [3:0]    mf;
    logic [FB-1:0] susp;
    logic [7:0]    ses;
  } row_t;

  // flt 15 = fault-free circuit
  localparam row_t ROWS [6] = '{
    '{4'd3,  4'd1, 4'd5, 10'h008, 8'd4},  // R9 stop on resolution, R4/R5 moves
    '{4'd3,  4'd0, 4'd5, 10'h008, 8'd6},  // R7 rebuild, R8 sequence end
    '{4'd1,  4'd0, 4'd5, 10'h002, 8'd9},  // R5 shrink, R6 AND, R7 restarts
    '{4'd1,  4'd0, 4'd2, 10'h002, 8'd3},  // R10 stop on failure count
    '{4'd15, 4'd0, 4'd5, 10'h000, 8'd4},  // R2/R3/R8 fault-free clears all
    '{4'd9,  4'd0, 4'd5, 10'h301, 8'd4}   // R11 isolation of last entry
  };

  logic [7:0] lf_at [13];
  logic [7:0] mg_at [13];
  logic [3:0] cur_flt;
  logic       inj;
  int checks = 0;
  int fails  = 0;

  function automatic logic [7:0] nxt(input logic [7:0] x);
    logic [7:0] y;
    y = x << 1;
    if (x[7]) y = y ^ 8'h1D;
    return y;
  endfunction

  function automatic logic [7:0] gold(input logic [7:0] p);
    return {p[3:0], p[7:4]} ^ 8'hA5;
  endfunction

  always_comb begin
    inj = 1'b0;
    for (int k = 0; k < NDP; k++)
      if (cur_flt < 4'd10 && pat == lf_at[ENT_PAT[k]] && ENT_FLT[k][cur_flt]) inj = 1'b1;
    cut = gold(pat) ^ {7'b0, inj};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) begin
      checks++; fails++;
      $display("FAIL watchdog: no done pulse");
    end
  endtask

  initial begin
    bit ok;
    logic [FB-1:0] hs;
    logic [7:0]    hn;
    rst = 1'b1; start = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_pat = '0;
    wr_lfsr = '0; wr_sig = '0; wr_flt = '0; cfg_res = '0; cfg_mf = 4'd1;
    cur_flt = 4'd15;
    lf_at[0] = 8'h00; mg_at[0] = 8'h00;
    lf_at[1] = 8'h01;
    for (int p = 1; p <= 12; p++) begin
      mg_at[p] = nxt(mg_at[p-1]) ^ gold(lf_at[p]);
      if (p < 12) lf_at[p+1] = nxt(lf_at[p]);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 sessions", {24'b0, ses}, 32'd0);
    chk("R1 suspected", {22'b0, susp}, 32'd0);
    rst = 1'b0;
    for (int k = 0; k < NDP; k++) begin
      wr_en = 1'b1; wr_addr = 3'(k); wr_pat = ENT_PAT[k];
      wr_lfsr = nxt(lf_at[ENT_PAT[k]]); wr_sig = mg_at[ENT_PAT[k]];
      wr_flt = ENT_FLT[k];
      @(negedge clk);
    end
    wr_en = 1'b0;
    for (int r = 0; r < 6; r++) begin
      cur_flt = ROWS[r].flt; cfg_res = ROWS[r].thr; cfg_mf = ROWS[r].mf;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      if (!ok) break;
      chk($sformatf("R6/R8 row %0d suspected", r), {22'b0, susp}, {22'b0, ROWS[r].susp});
      chk($sformatf("R3 row %0d sessions", r), {24'b0, ses}, {24'b0, ROWS[r].ses});
    end
    // R12: single-cycle pulse, results held
    hs = susp; hn = ses;
    @(negedge clk);
    chk("R12 done pulse width", {31'b0, done}, 32'd0);
    repeat (20) @(negedge clk);
    chk("R12 suspected held", {22'b0, susp}, {22'b0, hs});
    chk("R12 sessions held", {24'b0, ses}, {24'b0, hn});
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog: global timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule